// File: doc/BRIEF.md
# Flash command decoder

This block is the device-side control logic of a byte-wide flash memory driven by unlock command sequences. It watches the write cycles presented on a parallel bus made of an address, a data byte, an active-low chip select and an active-low write enable. It recognises the multi-cycle program and erase commands, and then runs a simulated embedded algorithm whose length is a cycle count. While that algorithm runs, a read does not return array data. It returns a polling status instead: bit 7 holds the complement of the data being written, and the other bits read as zero.

The array is a small register file of `SECTORS` equal sectors of `SECTOR_BYTES` bytes each. Erase sets bytes to FFh. Programming can only clear bits. A bus master issues commands one write at a time, then polls any address until bit 7 matches the written data. All bus inputs are synchronous to `clk`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write is taken when the combined strobe (high while either `ce_n` or `we_n` is high) rises. The address is captured when that strobe falls and the data when it rises, so either `we_n` or `ce_n` may be the controlling signal.
- R2: The sequence AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then data D at address X programs the byte at X. The byte index is taken from the low address bits.
- R3: A program leaves the byte equal to its old value AND D; no bit goes from 0 to 1.
- R4: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h erases the whole array to FFh.
- R5: The same five-write prefix followed by 30h at any address selects the sector addressed by the upper byte-index bits. Each further 30h write arriving within `SECT_WIN_CYC` cycles of the previously accepted one adds its sector. The erase starts when the window runs out, sets the selected sectors to FFh and leaves all other sectors unchanged.
- R6: Any write that does not match the expected address/data at its step returns the decoder to idle and leaves the array unchanged. During the sector window, a write of any value other than 30h abandons the pending erase.
- R7: A program is busy for `PROG_CYC` cycles and an erase for `ERASE_CYC` cycles. During that time a read returns bit 7 = NOT(written bit 7) and bits 6:0 = 0. Erase counts as writing FFh, so it reads 00h.
- R8: Bus writes that arrive while an operation is busy are ignored and do not advance the command decoder.
- R9: A read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1) gives `dout_en`=1 one clock later, with `dout` set to the byte at the low address bits (or the status of R7). Any other cycle gives `dout_en`=0 and `dout`=00h.
- R10: After reset every array byte reads FFh and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status, registered |
| dout_en | output | 1 | High when `dout` carries a read result |

## Verification
The bench builds the block with 8 sectors of 4 bytes, `PROG_CYC`=6, `ERASE_CYC`=60 and `SECT_WIN_CYC`=16. With a 60-cycle erase, a complete four-write program command fits inside a single busy period, which exercises the rule that writes during busy are ignored. With a 16-cycle window, a second sector-select write or an abandoning write falls inside the window, while the erase still starts soon afterwards. A 32-byte array lets every sector boundary and polling case be read back in a short run.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  CODE_KEY1  = 8'hAA;
  localparam logic [7:0]  CODE_KEY2  = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERASE = 8'h80;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_SECT  = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PDATA, ST_EKEY1, ST_EKEY2, ST_ESEL, ST_SWIN
  } cmd_state_t;
endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic              strobe, strobe_q;
  logic              fall, rise;
  logic [ADDR_W-1:0] addr_hold, addr_hold_n;
  logic [ADDR_W-1:0] wr_addr_n;
  logic [7:0]        wr_data_n;

  assign strobe = ce_n | we_n;
  assign fall   = strobe_q & ~strobe;
  assign rise   = ~strobe_q & strobe;

  always_comb begin
    addr_hold_n = addr_hold;
    wr_addr_n   = wr_addr;
    wr_data_n   = wr_data;
    if (fall) addr_hold_n = addr;
    if (rise) begin
      wr_addr_n = addr_hold;
      wr_data_n = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b1;
      addr_hold <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      strobe_q  <= strobe;
      addr_hold <= addr_hold_n;
      wr_valid  <= rise;
      wr_addr   <= wr_addr_n;
      wr_data   <= wr_data_n;
    end
  end

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

// File: rtl/fcd_cmd_seq.sv
module fcd_cmd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int IDX_W        = 5,
  parameter int SEC_W        = 3,
  parameter int SECTORS      = 8,
  parameter int SECT_WIN_CYC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               busy,
  output logic               prog_go,
  output logic [IDX_W-1:0]   prog_idx,
  output logic [7:0]         prog_data,
  output logic               erase_go,
  output logic [SECTORS-1:0] erase_mask
);
  localparam int WIN_W = $clog2(SECT_WIN_CYC + 1);

  cmd_state_t         st, st_n;
  logic [SECTORS-1:0] sel, sel_n, onehot;
  logic [WIN_W-1:0]   win, win_n;
  logic               prog_go_n, erase_go_n;
  logic [IDX_W-1:0]   prog_idx_n;
  logic [7:0]         prog_data_n;
  logic [SECTORS-1:0] erase_mask_n;
  logic               hit_a, hit_b, take;

  assign hit_a  = (wr_addr == ADDR_W'(UNLOCK_ADDR_A));
  assign hit_b  = (wr_addr == ADDR_W'(UNLOCK_ADDR_B));
  assign onehot = SECTORS'(1) << wr_addr[IDX_W-1 -: SEC_W];
  assign take   = wr_valid & ~busy;

  always_comb begin
    st_n         = st;
    sel_n        = sel;
    win_n        = win;
    prog_go_n    = 1'b0;
    erase_go_n   = 1'b0;
    prog_idx_n   = prog_idx;
    prog_data_n  = prog_data;
    erase_mask_n = erase_mask;
    if (take) begin
      st_n = ST_IDLE;
      unique case (st)
        ST_IDLE:  if (hit_a && wr_data == CODE_KEY1) st_n = ST_KEY1;
        ST_KEY1:  if (hit_b && wr_data == CODE_KEY2) st_n = ST_KEY2;
        ST_KEY2: begin
          if (hit_a && wr_data == CODE_PROG)  st_n = ST_PDATA;
          if (hit_a && wr_data == CODE_ERASE) st_n = ST_EKEY1;
        end
        ST_PDATA: begin
          prog_go_n   = 1'b1;
          prog_idx_n  = wr_addr[IDX_W-1:0];
          prog_data_n = wr_data;
        end
        ST_EKEY1: if (hit_a && wr_data == CODE_KEY1) st_n = ST_EKEY2;
        ST_EKEY2: if (hit_b && wr_data == CODE_KEY2) st_n = ST_ESEL;
        ST_ESEL: begin
          if (hit_a && wr_data == CODE_CHIP) begin
            erase_go_n   = 1'b1;
            erase_mask_n = '1;
          end else if (wr_data == CODE_SECT) begin
            sel_n = onehot;
            win_n = WIN_W'(SECT_WIN_CYC - 1);
            st_n  = ST_SWIN;
          end
        end
        ST_SWIN: begin
          if (wr_data == CODE_SECT) begin
            sel_n = sel | onehot;
            win_n = WIN_W'(SECT_WIN_CYC - 1);
            st_n  = ST_SWIN;
          end else begin
            sel_n = '0;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end else if (st == ST_SWIN) begin
      if (win == '0) begin
        erase_go_n   = 1'b1;
        erase_mask_n = sel;
        sel_n        = '0;
        st_n         = ST_IDLE;
      end else begin
        win_n = win - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sel        <= '0;
      win        <= '0;
      prog_go    <= 1'b0;
      erase_go   <= 1'b0;
      prog_idx   <= '0;
      prog_data  <= '0;
      erase_mask <= '0;
    end else begin
      st         <= st_n;
      sel        <= sel_n;
      win        <= win_n;
      prog_go    <= prog_go_n;
      erase_go   <= erase_go_n;
      prog_idx   <= prog_idx_n;
      prog_data  <= prog_data_n;
      erase_mask <= erase_mask_n;
    end
  end

  assert_go_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_go && erase_go));
  assert_mask_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (erase_mask != '0));
  assert_window_abandon_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWIN && take && wr_data != CODE_SECT) |=> (st == ST_IDLE && !erase_go));
endmodule

// File: rtl/fcd_array_engine.sv
module fcd_array_engine #(
  parameter int IDX_W        = 5,
  parameter int SECTORS      = 8,
  parameter int SECTOR_BYTES = 4,
  parameter int PROG_CYC     = 8,
  parameter int ERASE_CYC    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_go,
  input  logic [IDX_W-1:0]   prog_idx,
  input  logic [7:0]         prog_data,
  input  logic               erase_go,
  input  logic [SECTORS-1:0] erase_mask,
  input  logic               rd,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               busy,
  output logic [7:0]         dout,
  output logic               dout_en
);
  localparam int DEPTH = SECTORS * SECTOR_BYTES;
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [DEPTH-1:0][7:0] mem;
  logic [CNT_W-1:0]      cnt, cnt_n;
  logic                  busy_n, finish;
  logic                  op_prog, op_prog_n;
  logic [IDX_W-1:0]      op_idx, op_idx_n;
  logic [7:0]            op_data, op_data_n;
  logic [SECTORS-1:0]    op_mask, op_mask_n;
  logic [7:0]            dout_n;

  assign finish = busy & (cnt == '0);

  always_comb begin
    busy_n    = busy;
    cnt_n     = cnt;
    op_prog_n = op_prog;
    op_idx_n  = op_idx;
    op_data_n = op_data;
    op_mask_n = op_mask;
    if (busy) begin
      if (finish) busy_n = 1'b0;
      else        cnt_n  = cnt - 1'b1;
    end else if (prog_go) begin
      busy_n    = 1'b1;
      cnt_n     = CNT_W'(PROG_CYC - 1);
      op_prog_n = 1'b1;
      op_idx_n  = prog_idx;
      op_data_n = prog_data;
    end else if (erase_go) begin
      busy_n    = 1'b1;
      cnt_n     = CNT_W'(ERASE_CYC - 1);
      op_prog_n = 1'b0;
      op_data_n = 8'hFF;
      op_mask_n = erase_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      op_prog <= 1'b0;
      op_idx  <= '0;
      op_data <= '0;
      op_mask <= '0;
    end else begin
      busy    <= busy_n;
      cnt     <= cnt_n;
      op_prog <= op_prog_n;
      op_idx  <= op_idx_n;
      op_data <= op_data_n;
      op_mask <= op_mask_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam int SEC = g / SECTOR_BYTES;
    logic upd;
    assign upd = finish & (op_prog ? (op_idx == IDX_W'(g)) : op_mask[SEC]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= 8'hFF;
      else if (upd) mem[g] <= op_prog ? (mem[g] & op_data) : 8'hFF;
    end
  end

  always_comb begin
    dout_n = 8'h00;
    if (rd) dout_n = busy ? {~op_data[7], 7'b0} : mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 8'h00;
      dout_en <= 1'b0;
    end else begin
      dout    <= dout_n;
      dout_en <= rd;
    end
  end

  assert_prog_clears_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op_prog) |=> ((mem & ~$past(mem)) == '0));
  assert_poll_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd) |=> (dout_en && dout[6:0] == 7'd0));
  assert_no_start_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go) |-> !busy);
  assert_array_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mem));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W       = 15,
  parameter int SECTORS      = 8,
  parameter int SECTOR_BYTES = 4,
  parameter int PROG_CYC     = 8,
  parameter int ERASE_CYC    = 32,
  parameter int SECT_WIN_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int IDX_W = $clog2(SECTORS * SECTOR_BYTES);
  localparam int SEC_W = $clog2(SECTORS);

  logic               wr_valid, busy, prog_go, erase_go, rd;
  logic [ADDR_W-1:0]  wr_addr;
  logic [7:0]         wr_data, prog_data;
  logic [IDX_W-1:0]   prog_idx;
  logic [SECTORS-1:0] erase_mask;

  assign rd = ~ce_n & ~oe_n & we_n;

  fcd_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcd_cmd_seq #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEC_W(SEC_W), .SECTORS(SECTORS),
    .SECT_WIN_CYC(SECT_WIN_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .prog_go(prog_go), .prog_idx(prog_idx), .prog_data(prog_data),
    .erase_go(erase_go), .erase_mask(erase_mask)
  );

  fcd_array_engine #(
    .IDX_W(IDX_W), .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_idx(prog_idx), .prog_data(prog_data),
    .erase_go(erase_go), .erase_mask(erase_mask), .rd(rd), .rd_idx(addr[IDX_W-1:0]),
    .busy(busy), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int PROG = 6;
  localparam int ERASE = 60;
  localparam int WIN = 16;
  localparam int SB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(15), .SECTORS(8), .SECTOR_BYTES(SB),
    .PROG_CYC(PROG), .ERASE_CYC(ERASE), .SECT_WIN_CYC(WIN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_mem [32];
  int       q_a[$];
  int       q_d[$];
  int       cyc;
  bit       prev_s;
  int       alat;
  bit       op_valid, op_prog;
  int       op_start, op_done, op_idx;
  bit [7:0] op_data, op_mask;
  bit       win_open;
  int       deadline;
  bit [7:0] win_mask;
  bit [7:0] exp_dout;
  bit       exp_en;

  function automatic int classify();
    int n = q_a.size();
    if (q_a[0] != 'h5555 || q_d[0] != 'hAA) return 0;
    if (n == 1) return 1;
    if (q_a[1] != 'h2AAA || q_d[1] != 'h55) return 0;
    if (n == 2) return 1;
    if (q_a[2] != 'h5555 || (q_d[2] != 'hA0 && q_d[2] != 'h80)) return 0;
    if (n == 3) return 1;
    if (q_d[2] == 'hA0) return 2;
    if (q_a[3] != 'h5555 || q_d[3] != 'hAA) return 0;
    if (n == 4) return 1;
    if (q_a[4] != 'h2AAA || q_d[4] != 'h55) return 0;
    if (n == 5) return 1;
    if (q_a[5] == 'h5555 && q_d[5] == 'h10) return 3;
    if (q_d[5] == 'h30) return 4;
    return 0;
  endfunction

  task automatic model_write(input int a, input int d, input int k);
    int c;
    if (op_valid && k < op_done) return;
    if (win_open) begin
      if (d == 'h30) begin
        win_mask[(a % 32) / SB] = 1'b1;
        deadline = k + WIN;
      end else win_open = 0;
      return;
    end
    q_a.push_back(a);
    q_d.push_back(d);
    c = classify();
    if (c == 1) return;
    if (c == 2) begin
      op_valid = 1; op_prog = 1; op_idx = a % 32; op_data = 8'(d);
      op_start = k + 2; op_done = k + 2 + PROG;
    end else if (c == 3) begin
      op_valid = 1; op_prog = 0; op_mask = 8'hFF; op_data = 8'hFF;
      op_start = k + 2; op_done = k + 2 + ERASE;
    end else if (c == 4) begin
      win_open = 1; win_mask = '0; win_mask[(a % 32) / SB] = 1'b1;
      deadline = k + WIN;
    end
    q_a.delete();
    q_d.delete();
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      q_a.delete(); q_d.delete();
      cyc = 0; prev_s = 1; alat = 0;
      op_valid = 0; win_open = 0;
      exp_dout = 0; exp_en = 0;
    end else begin
      bit rdc, now_s, busy_m;
      cyc++;
      rdc = !ce_n && !oe_n && we_n;
      busy_m = op_valid && cyc > op_start && cyc <= op_done;
      exp_en = rdc;
      exp_dout = !rdc ? 8'h00 : (busy_m ? {~op_data[7], 7'b0} : m_mem[addr % 32]);
      if (op_valid && cyc == op_done) begin
        if (op_prog) m_mem[op_idx] = m_mem[op_idx] & op_data;
        else foreach (m_mem[i]) if (op_mask[i / SB]) m_mem[i] = 8'hFF;
        op_valid = 0;
      end
      now_s = ce_n | we_n;
      if (prev_s && !now_s) alat = int'(addr);
      if (!prev_s && now_s) model_write(alat, int'(din), cyc);
      prev_s = now_s;
      if (win_open && cyc == deadline + 1) begin
        win_open = 0;
        op_valid = 1; op_prog = 0; op_mask = win_mask; op_data = 8'hFF;
        op_start = cyc + 1; op_done = cyc + 1 + ERASE;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (dout !== exp_dout || dout_en !== exp_en) begin
        mismatched++;
        $display("FAIL R7/R9 model compare cycle %0d: dout=%h en=%b expected dout=%h en=%b",
                 cyc, dout, dout_en, exp_dout, exp_en);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [14:0] a, input logic [7:0] d, input bit ce_ctl);
    @(negedge clk); addr = a; din = d;
    if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk);
    if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [14:0] a, output logic [7:0] v, output logic en);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    v = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic cmd_prog(input logic [14:0] a, input logic [7:0] d, input bit ce_ctl);
    bus_wr(15'h5555, 8'hAA, ce_ctl);
    bus_wr(15'h2AAA, 8'h55, ce_ctl);
    bus_wr(15'h5555, 8'hA0, ce_ctl);
    bus_wr(a, d, ce_ctl);
  endtask

  task automatic erase_prefix();
    bus_wr(15'h5555, 8'hAA, 0);
    bus_wr(15'h2AAA, 8'h55, 0);
    bus_wr(15'h5555, 8'h80, 0);
    bus_wr(15'h5555, 8'hAA, 0);
    bus_wr(15'h2AAA, 8'h55, 0);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic en;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R10: erased after reset; R9: read enables output
    bus_rd(15'd0, v, en);  check("R10 reset byte 0", v, 8'hFF); check("R9 dout_en on read", {7'b0, en}, 8'h01);
    bus_rd(15'd31, v, en); check("R10 reset byte 31", v, 8'hFF);
    // R9: no read with oe_n high
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 15'd0;
    wait_cyc(2); check("R9 dout_en idle", {7'b0, dout_en}, 8'h00); check("R9 dout idle", dout, 8'h00);
    ce_n = 1'b1;

    // R2 + R7: program, polling shows complement of bit 7
    cmd_prog(15'd3, 8'h5A, 0);
    bus_rd(15'd3, v, en); check("R7 poll during program", v, 8'h80);
    wait_cyc(PROG + 4);
    bus_rd(15'd3, v, en); check("R2 programmed byte", v, 8'h5A);

    // R1 + R3: chip-select controlled write, AND with old content
    cmd_prog(15'd3, 8'hF0, 1);
    wait_cyc(PROG + 4);
    bus_rd(15'd3, v, en); check("R3 R1 and-program via ce_n", v, 8'h50);

    cmd_prog(15'd9, 8'h81, 1);
    bus_rd(15'd9, v, en); check("R7 poll bit7 set data", v, 8'h00);
    wait_cyc(PROG + 4);
    bus_rd(15'd9, v, en); check("R2 programmed byte 9", v, 8'h81);

    // R6: broken sequences
    bus_wr(15'h5555, 8'hAA, 0); bus_wr(15'h2AAA, 8'h55, 0);
    bus_wr(15'h5555, 8'h77, 0); bus_wr(15'd9, 8'h00, 0);
    wait_cyc(PROG + 4);
    bus_rd(15'd9, v, en); check("R6 bad command code", v, 8'h81);
    bus_wr(15'h5554, 8'hAA, 0); bus_wr(15'h2AAA, 8'h55, 0);
    bus_wr(15'h5555, 8'hA0, 0); bus_wr(15'd9, 8'h00, 0);
    wait_cyc(PROG + 4);
    bus_rd(15'd9, v, en); check("R6 bad unlock address", v, 8'h81);

    // R5: multi-sector erase
    cmd_prog(15'd4, 8'h00, 0);  wait_cyc(PROG + 4);
    cmd_prog(15'd8, 8'h00, 0);  wait_cyc(PROG + 4);
    cmd_prog(15'd20, 8'h00, 0); wait_cyc(PROG + 4);
    erase_prefix();
    bus_wr(15'd4, 8'h30, 0);
    bus_wr(15'd21, 8'h30, 0);
    wait_cyc(WIN + 2);
    bus_rd(15'd8, v, en); check("R7 poll during erase", v, 8'h00);
    wait_cyc(ERASE + 4);
    bus_rd(15'd4, v, en);  check("R5 sector 1 erased", v, 8'hFF);
    bus_rd(15'd20, v, en); check("R5 sector 5 erased", v, 8'hFF);
    bus_rd(15'd8, v, en);  check("R5 sector 2 untouched", v, 8'h00);

    // R6: non-30h write inside the window abandons the erase
    erase_prefix();
    bus_wr(15'd8, 8'h30, 0);
    bus_wr(15'd8, 8'h11, 0);
    wait_cyc(WIN + ERASE + 8);
    bus_rd(15'd8, v, en); check("R6 abandoned sector erase", v, 8'h00);

    // R4 + R8: chip erase, program command issued while busy is ignored
    erase_prefix();
    bus_wr(15'h5555, 8'h10, 0);
    cmd_prog(15'd16, 8'h0F, 0);
    wait_cyc(ERASE + 4);
    bus_rd(15'd16, v, en); check("R8 write during busy ignored", v, 8'hFF);
    bus_rd(15'd8, v, en);  check("R4 chip erase byte 8", v, 8'hFF);
    bus_rd(15'd3, v, en);  check("R4 chip erase byte 3", v, 8'hFF);

    cmd_prog(15'd16, 8'h3C, 0);
    wait_cyc(PROG + 4);
    bus_rd(15'd16, v, en); check("R2 program after erase", v, 8'h3C);

    wait_cyc(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule